// File: doc/BRIEF.md
# Speculative-Buffering Coherence Line Controller

This block tracks the coherence state of one cache line on a snoopy bus. It runs the usual four-state invalidation protocol (modified, exclusive, shared, invalid) and adds two speculative states. SPEC_MOD holds a value written by a transactional store that no other agent may see yet. SPEC_RD holds a transactionally read copy that is kept apart from other agents' speculative writes. Because several lines may sit in SPEC_MOD at once in different caches, many speculative writers can run side by side. Commit and abort are purely local: they change state and put nothing on the bus.

The local core issues one operation at a time on `cpu_op`: plain load, plain store, transactional load, transactional store, commit, abort, or evict (replacement). A miss raises a bus request and moves the controller into one of four waiting states. It stays there until the fill response arrives, and that response carries a shared flag and a threatened flag. Snooped requests (read, read-for-ownership, transactional read-for-ownership) are answered in the cycle after they are seen. The answer can enable data supply, flush modified data, mark the line shared, or mark it threatened. When a speculative line would be lost, the controller raises an alert to the running thread.

States: ST_INV, ST_SHR, ST_EXC, ST_MOD, ST_SPEC_RD, ST_SPEC_MOD, and the waiting states ST_WAIT_RD (load fill), ST_WAIT_TRD (transactional load fill), ST_WAIT_RDX (store fill) and ST_WAIT_TRDX (transactional store fill). Transitions: load miss, load hit, store miss, store upgrade, silent store, transactional load miss, transactional store miss, transactional store from exclusive, transactional store from modified with flush, commit, abort, evict, snoop downgrade, snoop invalidate, snoop ignore, snoop threaten, and fill.

Top module: `tmesi_line_ctrl`

## Requirements
- R1: After reset `line_state` is 0 (ST_INV) and every pulse output is low. The state codes are INV=0, SHR=1, EXC=2, MOD=3, SPEC_RD=4, SPEC_MOD=5, WAIT_RD=6, WAIT_TRD=7, WAIT_RDX=8 and WAIT_TRDX=9. The bus op codes are READ=0, READ_EXCL=1 and TREAD_EXCL=2. The cpu op codes are NOP=0, LOAD=1, STORE=2, TLOAD=3, TSTORE=4, COMMIT=5, ABORT=6 and EVICT=7.
- R2: A load miss from INV issues READ and enters WAIT_RD. Its fill goes to SHR if shared and to EXC otherwise. A store miss from INV or SHR issues READ_EXCL, and its fill goes to MOD. A store to EXC goes to MOD with no request. All outputs appear one cycle after their cause.
- R3: A transactional store to INV, SHR or SPEC_RD issues TREAD_EXCL, and its fill goes to SPEC_MOD. From EXC it goes to SPEC_MOD silently. From MOD it goes to SPEC_MOD and pulses `wb_flush` to save the committed value.
- R4: A transactional load miss issues READ. A fill with the threatened flag goes to SPEC_RD. Otherwise it goes to SHR if shared and to EXC if not.
- R5: A snooped TREAD_EXCL to SPEC_MOD or SPEC_RD is ignored: the state is unchanged and supply, threat and alert stay low.
- R6: A snooped READ to SPEC_MOD pulses `snp_threat`, keeps `snp_supply` low, and leaves the line in SPEC_MOD.
- R7: COMMIT moves SPEC_MOD to MOD and SPEC_RD to INV, pulses `cpu_done`, and issues no bus request.
- R8: ABORT moves SPEC_MOD and SPEC_RD to INV, leaves the other stable states unchanged, pulses `cpu_done`, and issues no bus request.
- R9: EVICT always ends in INV. From SPEC_MOD it pulses `spec_alert`; from SPEC_RD it is silent; from MOD it pulses `wb_flush`.
- R10: A snooped READ_EXCL to SPEC_MOD or SPEC_RD moves the line to INV and pulses `spec_alert`.
- R11: Snoops to non-speculative lines follow the invalidation protocol. READ to MOD supplies and flushes the data, asserts shared, and goes to SHR. READ to EXC or SHR asserts shared, and EXC goes to SHR. READ_EXCL or TREAD_EXCL to MOD supplies and flushes the data and goes to INV. To EXC or SHR either one goes to INV.
- R12: A snoop takes priority over a cpu operation in the same cycle, and that cpu operation is dropped. In a waiting state, cpu operations and snoops are ignored until the fill arrives, and `cpu_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Local operation present |
| cpu_op | input | 3 | Local operation code |
| cpu_ready | output | 1 | High when not waiting for a fill |
| cpu_done | output | 1 | Local operation completed (pulse) |
| snp_valid | input | 1 | Snooped request present |
| snp_op | input | 2 | Snooped bus op code |
| snp_supply | output | 1 | Enable data supply to the bus |
| snp_shared | output | 1 | Line is held, report shared |
| snp_threat | output | 1 | Threatened response, data withheld |
| wb_flush | output | 1 | Write modified data back (pulse) |
| req_valid | output | 1 | Bus request issued (pulse) |
| req_op | output | 2 | Bus request op code |
| fill_valid | input | 1 | Fill response for the pending request |
| fill_shared | input | 1 | Fill reports another sharer |
| fill_threat | input | 1 | Fill reports a speculative writer |
| spec_alert | output | 1 | Speculative line lost (pulse) |
| line_state | output | 4 | Current state code |

## Verification
The assertions assume three things about the inputs. `fill_valid` arrives only while a request is outstanding. A cpu operation is presented only while `cpu_ready` is high, except in the deliberate R12 cases, where the drop is itself what is checked. `snp_op` never carries the unused code 3. The stimulus drives one stimulus per cycle on idle negative-edge slots and raises a fill only after it has seen a request. A few cycles combine a snoop with a cpu operation on purpose, to exercise the priority rule.

// File: rtl/tmesi_pkg.sv
package tmesi_pkg;
    localparam int STATE_W = 4;
    localparam int CPU_OP_W = 3;
    localparam int BUS_OP_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_INV       = 4'd0,
        ST_SHR       = 4'd1,
        ST_EXC       = 4'd2,
        ST_MOD       = 4'd3,
        ST_SPEC_RD   = 4'd4,
        ST_SPEC_MOD  = 4'd5,
        ST_WAIT_RD   = 4'd6,
        ST_WAIT_TRD  = 4'd7,
        ST_WAIT_RDX  = 4'd8,
        ST_WAIT_TRDX = 4'd9
    } line_state_e;

    typedef enum logic [CPU_OP_W-1:0] {
        OP_NOP    = 3'd0,
        OP_LOAD   = 3'd1,
        OP_STORE  = 3'd2,
        OP_TLOAD  = 3'd3,
        OP_TSTORE = 3'd4,
        OP_COMMIT = 3'd5,
        OP_ABORT  = 3'd6,
        OP_EVICT  = 3'd7
    } cpu_op_e;

    typedef enum logic [BUS_OP_W-1:0] {
        BUS_READ       = 2'd0,
        BUS_READ_EXCL  = 2'd1,
        BUS_TREAD_EXCL = 2'd2,
        BUS_UNUSED     = 2'd3
    } bus_op_e;

    typedef struct packed {
        logic    req_valid;
        bus_op_e req_op;
        logic    supply;
        logic    flush;
        logic    threat;
        logic    shared;
        logic    alert;
        logic    done;
    } line_action_t;

    function automatic logic is_waiting(line_state_e s);
        return (s == ST_WAIT_RD) || (s == ST_WAIT_TRD) ||
               (s == ST_WAIT_RDX) || (s == ST_WAIT_TRDX);
    endfunction

    function automatic logic is_spec(line_state_e s);
        return (s == ST_SPEC_RD) || (s == ST_SPEC_MOD);
    endfunction
endpackage

// File: rtl/tmesi_fill_path.sv
module tmesi_fill_path
    import tmesi_pkg::*;
(
    input  line_state_e  cur_state,
    input  logic         fill_shared,
    input  logic         fill_threat,
    output line_state_e  fill_state
);
    always_comb begin
        unique case (cur_state)
            ST_WAIT_RD:   fill_state = fill_shared ? ST_SHR : ST_EXC;
            ST_WAIT_TRD:  fill_state = fill_threat ? ST_SPEC_RD
                                     : (fill_shared ? ST_SHR : ST_EXC);
            ST_WAIT_RDX:  fill_state = ST_MOD;
            ST_WAIT_TRDX: fill_state = ST_SPEC_MOD;
            default:      fill_state = cur_state;
        endcase
    end
endmodule

// File: rtl/tmesi_snoop_path.sv
module tmesi_snoop_path
    import tmesi_pkg::*;
(
    input  line_state_e  cur_state,
    input  bus_op_e      snp_op,
    output line_state_e  snp_state,
    output line_action_t snp_act
);
    always_comb begin
        snp_state = cur_state;
        snp_act   = '0;
        snp_act.req_op = BUS_READ;
        unique case (cur_state)
            ST_SHR: begin
                if (snp_op == BUS_READ) begin
                    snp_act.shared = 1'b1;
                end else if (snp_op != BUS_UNUSED) begin
                    snp_state = ST_INV;
                end
            end
            ST_EXC: begin
                if (snp_op == BUS_READ) begin
                    snp_state      = ST_SHR;
                    snp_act.shared = 1'b1;
                end else if (snp_op != BUS_UNUSED) begin
                    snp_state = ST_INV;
                end
            end
            ST_MOD: begin
                if (snp_op == BUS_READ) begin
                    snp_state      = ST_SHR;
                    snp_act.supply = 1'b1;
                    snp_act.flush  = 1'b1;
                    snp_act.shared = 1'b1;
                end else if (snp_op != BUS_UNUSED) begin
                    snp_state      = ST_INV;
                    snp_act.supply = 1'b1;
                    snp_act.flush  = 1'b1;
                end
            end
            ST_SPEC_RD: begin
                if (snp_op == BUS_READ) begin
                    snp_act.shared = 1'b1;
                end else if (snp_op == BUS_READ_EXCL) begin
                    snp_state     = ST_INV;
                    snp_act.alert = 1'b1;
                end
            end
            ST_SPEC_MOD: begin
                if (snp_op == BUS_READ) begin
                    snp_act.threat = 1'b1;
                end else if (snp_op == BUS_READ_EXCL) begin
                    snp_state     = ST_INV;
                    snp_act.alert = 1'b1;
                end
            end
            default: begin
                snp_state = cur_state;
            end
        endcase
    end
endmodule

// File: rtl/tmesi_cpu_path.sv
module tmesi_cpu_path
    import tmesi_pkg::*;
(
    input  line_state_e  cur_state,
    input  cpu_op_e      op,
    output line_state_e  cpu_state,
    output line_action_t cpu_act
);
    always_comb begin
        cpu_state = cur_state;
        cpu_act   = '0;
        cpu_act.req_op = BUS_READ;
        unique case (op)
            OP_NOP: begin
                cpu_state = cur_state;
            end
            OP_LOAD, OP_TLOAD: begin
                if (cur_state == ST_INV) begin
                    cpu_state         = (op == OP_TLOAD) ? ST_WAIT_TRD : ST_WAIT_RD;
                    cpu_act.req_valid = 1'b1;
                    cpu_act.req_op    = BUS_READ;
                end else begin
                    cpu_act.done = 1'b1;
                end
            end
            OP_STORE: begin
                unique case (cur_state)
                    ST_INV, ST_SHR, ST_SPEC_RD: begin
                        cpu_state         = ST_WAIT_RDX;
                        cpu_act.req_valid = 1'b1;
                        cpu_act.req_op    = BUS_READ_EXCL;
                    end
                    ST_EXC, ST_MOD: begin
                        cpu_state    = ST_MOD;
                        cpu_act.done = 1'b1;
                    end
                    default: begin
                        cpu_act.done = 1'b1;
                    end
                endcase
            end
            OP_TSTORE: begin
                unique case (cur_state)
                    ST_INV, ST_SHR, ST_SPEC_RD: begin
                        cpu_state         = ST_WAIT_TRDX;
                        cpu_act.req_valid = 1'b1;
                        cpu_act.req_op    = BUS_TREAD_EXCL;
                    end
                    ST_EXC: begin
                        cpu_state    = ST_SPEC_MOD;
                        cpu_act.done = 1'b1;
                    end
                    ST_MOD: begin
                        cpu_state     = ST_SPEC_MOD;
                        cpu_act.flush = 1'b1;
                        cpu_act.done  = 1'b1;
                    end
                    default: begin
                        cpu_act.done = 1'b1;
                    end
                endcase
            end
            OP_COMMIT: begin
                if (cur_state == ST_SPEC_MOD)     cpu_state = ST_MOD;
                else if (cur_state == ST_SPEC_RD) cpu_state = ST_INV;
                cpu_act.done = 1'b1;
            end
            OP_ABORT: begin
                if (is_spec(cur_state)) cpu_state = ST_INV;
                cpu_act.done = 1'b1;
            end
            OP_EVICT: begin
                cpu_state     = ST_INV;
                cpu_act.flush = (cur_state == ST_MOD);
                cpu_act.alert = (cur_state == ST_SPEC_MOD);
                cpu_act.done  = 1'b1;
            end
            default: begin
                cpu_state = cur_state;
            end
        endcase
    end
endmodule

// File: rtl/tmesi_line_ctrl.sv
module tmesi_line_ctrl
    import tmesi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_valid,
    input  logic [2:0] cpu_op,
    output logic       cpu_ready,
    output logic       cpu_done,
    input  logic       snp_valid,
    input  logic [1:0] snp_op,
    output logic       snp_supply,
    output logic       snp_shared,
    output logic       snp_threat,
    output logic       wb_flush,
    output logic       req_valid,
    output logic [1:0] req_op,
    input  logic       fill_valid,
    input  logic       fill_shared,
    input  logic       fill_threat,
    output logic       spec_alert,
    output logic [3:0] line_state
);
    line_state_e  state_q, state_d;
    line_state_e  fill_state, snp_state, cpu_state;
    line_action_t snp_act, cpu_act, act_d, act_q;
    logic         waiting;

    assign waiting = is_waiting(state_q);

    tmesi_fill_path u_fill (
        .cur_state   (state_q),
        .fill_shared (fill_shared),
        .fill_threat (fill_threat),
        .fill_state  (fill_state)
    );

    tmesi_snoop_path u_snoop (
        .cur_state (state_q),
        .snp_op    (bus_op_e'(snp_op)),
        .snp_state (snp_state),
        .snp_act   (snp_act)
    );

    tmesi_cpu_path u_cpu (
        .cur_state (state_q),
        .op        (cpu_op_e'(cpu_op)),
        .cpu_state (cpu_state),
        .cpu_act   (cpu_act)
    );

    // Arbitration: fill while waiting, else snoop over local op
    always_comb begin
        state_d = state_q;
        act_d   = '0;
        act_d.req_op = BUS_READ;
        if (waiting) begin
            if (fill_valid) begin
                state_d    = fill_state;
                act_d.done = 1'b1;
            end
        end else if (snp_valid) begin
            state_d = snp_state;
            act_d   = snp_act;
        end else if (cpu_valid) begin
            state_d = cpu_state;
            act_d   = cpu_act;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INV;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q        <= '0;
            act_q.req_op <= BUS_READ;
        end else begin
            act_q <= act_d;
        end
    end

    assign cpu_ready  = !waiting;
    assign cpu_done   = act_q.done;
    assign snp_supply = act_q.supply;
    assign snp_shared = act_q.shared;
    assign snp_threat = act_q.threat;
    assign wb_flush   = act_q.flush;
    assign req_valid  = act_q.req_valid;
    assign req_op     = act_q.req_op;
    assign spec_alert = act_q.alert;
    assign line_state = state_q;

    assert_tmod_ignores_trdx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPEC_MOD && snp_valid && snp_op == 2'd2)
        |=> (state_q == ST_SPEC_MOD && !snp_supply && !snp_threat && !spec_alert));

    assert_threat_withholds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPEC_MOD && snp_valid && snp_op == 2'd0)
        |=> (snp_threat && !snp_supply && state_q == ST_SPEC_MOD));

    assert_commit_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!waiting && !snp_valid && cpu_valid && (cpu_op == 3'd5 || cpu_op == 3'd6))
        |=> (!req_valid && cpu_done));

    assert_rd_evict_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPEC_RD && !snp_valid && cpu_valid && cpu_op == 3'd7)
        |=> (!spec_alert && state_q == ST_INV));

    assert_alert_from_spec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !is_spec(state_q) |=> !spec_alert);

    assert_wait_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !fill_valid) |=> (!cpu_done && !snp_supply && !snp_shared && state_q == $past(state_q)));

    assert_supply_excl_threat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_supply && snp_threat));
endmodule

// File: tb/test_tmesi_line_ctrl.sv
module test_tmesi_line_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_valid = 1'b0;
    logic [2:0] cpu_op = 3'd0;
    logic cpu_ready, cpu_done;
    logic snp_valid = 1'b0;
    logic [1:0] snp_op = 2'd0;
    logic snp_supply, snp_shared, snp_threat, wb_flush;
    logic req_valid;
    logic [1:0] req_op;
    logic fill_valid = 1'b0, fill_shared = 1'b0, fill_threat = 1'b0;
    logic spec_alert;
    logic [3:0] line_state;

    always #5 clk = ~clk;

    tmesi_line_ctrl i_tmesi_line_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .snp_valid(snp_valid),
        .snp_op(snp_op), .snp_supply(snp_supply), .snp_shared(snp_shared),
        .snp_threat(snp_threat), .wb_flush(wb_flush), .req_valid(req_valid),
        .req_op(req_op), .fill_valid(fill_valid), .fill_shared(fill_shared),
        .fill_threat(fill_threat), .spec_alert(spec_alert), .line_state(line_state)
    );

    localparam logic [3:0] I = 0, S = 1, E = 2, M = 3, TI = 4, TM = 5;
    localparam logic [3:0] WRD = 6, WTRD = 7, WRDX = 8, WTRDX = 9;
    localparam logic [2:0] LD = 1, ST = 2, TLD = 3, TST = 4, CMT = 5, ABT = 6, EVT = 7;
    localparam logic [1:0] RD = 0, RDX = 1, TRDX = 2;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int         due_q[$];
    logic [3:0] st_q[$];
    logic [8:0] fl_q[$];
    string      tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    // flags: {req_valid, req_op, supply, flush, threat, shared, alert, done}
    function automatic logic [8:0] F(input logic rv, input logic [1:0] rop,
        input logic sup, input logic fl, input logic thr, input logic shr,
        input logic al, input logic dn);
        return {rv, rop, sup, fl, thr, shr, al, dn};
    endfunction

    localparam logic [8:0] NONE = 9'b0;
    localparam logic [8:0] DONE = 9'b0_00_00000_1;

    // Monitor: compares outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            while (due_q.size() > 0 && due_q[0] == cyc) begin
                logic [8:0] act;
                act = {req_valid, req_op, snp_supply, wb_flush, snp_threat,
                       snp_shared, spec_alert, cpu_done};
                checks++;
                if (line_state !== st_q[0] || act !== fl_q[0]) begin
                    errors++;
                    $display("FAIL %s: state %0d flags %b, expected state %0d flags %b",
                             tag_q[0], line_state, act, st_q[0], fl_q[0]);
                end
                void'(due_q.pop_front()); void'(st_q.pop_front());
                void'(fl_q.pop_front()); void'(tag_q.pop_front());
            end
        end
    end

    // Driver: applies one stimulus cycle and queues the expected result
    task automatic step(input logic cv, input logic [2:0] cop, input logic sv,
        input logic [1:0] sop, input logic fv, input logic fsh, input logic fth,
        input logic [3:0] es, input logic [8:0] ef, input string tag);
        @(negedge clk);
        cpu_valid = cv; cpu_op = cop; snp_valid = sv; snp_op = sop;
        fill_valid = fv; fill_shared = fsh; fill_threat = fth;
        due_q.push_back(cyc + 1); st_q.push_back(es);
        fl_q.push_back(ef); tag_q.push_back(tag);
        @(negedge clk);
        cpu_valid = 0; cpu_op = 0; snp_valid = 0; snp_op = 0;
        fill_valid = 0; fill_shared = 0; fill_threat = 0;
    endtask

    task automatic cpu(input logic [2:0] op, input logic [3:0] es,
                       input logic [8:0] ef, input string tag);
        step(1, op, 0, 0, 0, 0, 0, es, ef, tag);
    endtask
    task automatic snp(input logic [1:0] op, input logic [3:0] es,
                       input logic [8:0] ef, input string tag);
        step(0, 0, 1, op, 0, 0, 0, es, ef, tag);
    endtask
    task automatic fill(input logic sh, input logic th, input logic [3:0] es,
                        input string tag);
        step(0, 0, 0, 0, 1, sh, th, es, DONE, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, I, NONE, "R1 reset state");

        cpu(LD, WRD, F(1, RD, 0,0,0,0,0,0), "R2 load miss issues READ");
        fill(0, 0, E, "R2 unshared fill to EXC");
        cpu(ST, M, DONE, "R2 silent store EXC to MOD");
        snp(RD, S, F(0,0,1,1,0,1,0,0), "R11 READ on MOD supplies and flushes");
        cpu(TST, WTRDX, F(1, TRDX, 0,0,0,0,0,0), "R3 tstore on SHR issues TREAD_EXCL");
        fill(0, 0, TM, "R3 fill to SPEC_MOD");
        snp(TRDX, TM, NONE, "R5 TREAD_EXCL ignored in SPEC_MOD");
        snp(RD, TM, F(0,0,0,0,1,0,0,0), "R6 READ threatened in SPEC_MOD");
        cpu(CMT, M, DONE, "R7 commit SPEC_MOD to MOD");
        cpu(TST, TM, F(0,0,0,1,0,0,0,1), "R3 tstore on MOD flushes");
        cpu(ABT, I, DONE, "R8 abort SPEC_MOD to INV");

        cpu(TLD, WTRD, F(1, RD, 0,0,0,0,0,0), "R4 tload miss issues READ");
        fill(0, 1, TI, "R4 threatened fill to SPEC_RD");
        snp(TRDX, TI, NONE, "R5 TREAD_EXCL ignored in SPEC_RD");
        cpu(CMT, I, DONE, "R7 commit SPEC_RD to INV");
        cpu(TLD, WTRD, F(1, RD, 0,0,0,0,0,0), "R4 tload miss again");
        fill(1, 0, S, "R4 shared fill to SHR");
        cpu(ABT, S, DONE, "R8 abort leaves SHR");
        cpu(TST, WTRDX, F(1, TRDX, 0,0,0,0,0,0), "R3 tstore on SHR");
        fill(0, 0, TM, "R3 fill to SPEC_MOD");
        cpu(EVT, I, F(0,0,0,0,0,0,1,1), "R9 evict SPEC_MOD alerts");

        cpu(ST, WRDX, F(1, RDX, 0,0,0,0,0,0), "R2 store miss issues READ_EXCL");
        cpu(LD, WRDX, NONE, "R12 cpu op ignored while waiting");
        snp(RD, WRDX, NONE, "R12 snoop ignored while waiting");
        fill(0, 0, M, "R2 store fill to MOD");
        cpu(EVT, I, F(0,0,0,1,0,0,0,1), "R9 evict MOD flushes");

        cpu(TLD, WTRD, F(1, RD, 0,0,0,0,0,0), "R4 tload miss");
        fill(0, 1, TI, "R4 threatened fill");
        cpu(EVT, I, DONE, "R9 evict SPEC_RD silent");
        cpu(TLD, WTRD, F(1, RD, 0,0,0,0,0,0), "R4 tload miss");
        fill(0, 1, TI, "R4 threatened fill");
        snp(RDX, I, F(0,0,0,0,0,0,1,0), "R10 READ_EXCL on SPEC_RD alerts");
        cpu(TST, WTRDX, F(1, TRDX, 0,0,0,0,0,0), "R3 tstore miss from INV");
        fill(1, 0, TM, "R3 fill to SPEC_MOD");
        snp(RDX, I, F(0,0,0,0,0,0,1,0), "R10 READ_EXCL on SPEC_MOD alerts");

        cpu(LD, WRD, F(1, RD, 0,0,0,0,0,0), "R2 load miss");
        fill(0, 0, E, "R2 fill to EXC");
        step(1, ST, 1, RD, 0, 0, 0, S, F(0,0,0,0,0,1,0,0), "R12 snoop wins over store");
        snp(RDX, I, NONE, "R11 READ_EXCL on SHR invalidates");
        cpu(LD, WRD, F(1, RD, 0,0,0,0,0,0), "R2 load miss");
        fill(1, 0, S, "R2 shared fill to SHR");
        cpu(ST, WRDX, F(1, RDX, 0,0,0,0,0,0), "R2 store upgrade from SHR");
        fill(0, 0, M, "R2 fill to MOD");
        snp(RDX, I, F(0,0,1,1,0,0,0,0), "R11 READ_EXCL on MOD supplies");
        cpu(LD, WRD, F(1, RD, 0,0,0,0,0,0), "R2 load miss");
        fill(0, 0, E, "R2 fill to EXC");
        cpu(TST, TM, DONE, "R3 tstore on EXC silent");
        cpu(CMT, M, DONE, "R7 commit to MOD");
        snp(TRDX, I, F(0,0,1,1,0,0,0,0), "R11 TREAD_EXCL on MOD supplies");
        snp(RD, I, NONE, "R11 snoop on INV no response");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run still busy, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule